// File: doc/BRIEF.md
# Express Virtual Channel Bypass Control

This block is the control logic for one input of an on-chip network router in which some virtual channels are express channels. An express channel is reserved across a run of several routers. Each incoming flit arrives with its virtual-channel number, an express flag, the output port chosen by routing, and the role this router plays for that channel. The role is normal, source, bypass or sink. The block decides, cycle by cycle, which of two paths the flit takes and when it asks the crossbar for its output port.

A flit on an express channel at a bypass router cannot lose any allocation. Its virtual channel is already reserved, and only one express channel can claim a given output. Such a flit therefore skips the input buffer and both allocators and requests the crossbar in the very next cycle. Every other flit is written into a FIFO. A flit in the FIFO spends three cycles at the head-of-line stages (route, channel allocation, switch allocation). It then asks an external switch allocator for a grant and is forwarded once granted.

A source router must also know that the next express endpoint has free buffer space. Express flits at a source router are therefore gated by a per-channel credit counter. Credits come back from downstream through a credit return input.

Top module: `evc_bypass_ctrl`

## Requirements
- R1: After reset, `xbar_valid`, `xbar_req`, `sa_req` and `path_code` are all zero.
- R2: The bypass path applies when `flit_express`=1 and `flit_role`=2 (bypass). Such a flit appears on the crossbar outputs in the next cycle, with `xbar_bypass`=1, bit `flit_port` of `xbar_req` set alone, and the same channel and data. It is never buffered.
- R3: A flit with `flit_express`=0 is buffered whatever its role. Its earliest crossbar appearance is 4 cycles after its arrival cycle, and it appears with `xbar_bypass`=0.
- R4: An express flit whose role is 0 (normal), 1 (source) or 3 (sink) takes the buffered path with the same 4-cycle minimum latency.
- R5: `sa_req` is high exactly when the FIFO head has been buffered for at least three cycles, its credit condition holds and no bypass flit arrives in that cycle. The head is forwarded in the next cycle only if `sa_gnt` is high together with `sa_req`. Otherwise it keeps waiting.
- R6: A bypass flit takes priority over a buffered head in the same cycle. `sa_req` is low in that cycle, and the head is forwarded no earlier than the following cycle.
- R7: Buffered flits leave in arrival order with their channel, port and data unchanged. The FIFO holds `BUF_DEPTH` flits, and the sender must not present a buffered flit while it is full.
- R8: Every channel has a credit counter that starts at `CREDITS`. A buffered express flit with role 1 (source) may request only while its channel has a credit above zero. Each such forwarding takes one credit. A pulse on `cred_ret_valid` returns one credit to channel `cred_ret_vc`.
- R9: In the cycle after a flit arrives, `path_code` reports its path: 1 for buffered, 2 for bypass. If no flit arrived, it reports 0.
- R10: Forwarding a non-express flit, or an express flit with role sink or normal, neither needs nor takes a credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | A flit is present this cycle |
| flit_express | input | 1 | The flit travels on an express channel |
| flit_role | input | 2 | Router role for the flit's channel: 0 normal, 1 source, 2 bypass, 3 sink |
| flit_vc | input | VC_W | Virtual-channel number of the flit |
| flit_port | input | PORT_W | Output port chosen by routing |
| flit_data | input | DATA_W | Flit payload |
| sa_gnt | input | 1 | Switch allocator grant for the buffered head |
| sa_req | output | 1 | Buffered head requests the switch allocator |
| cred_ret_valid | input | 1 | One downstream buffer slot was freed |
| cred_ret_vc | input | VC_W | Channel that the returned credit belongs to |
| xbar_valid | output | 1 | A flit traverses the crossbar this cycle |
| xbar_req | output | NUM_PORT | One-hot output-port request to the crossbar |
| xbar_bypass | output | 1 | The forwarded flit came through the bypass path |
| xbar_vc | output | VC_W | Channel of the forwarded flit |
| xbar_data | output | DATA_W | Payload of the forwarded flit |
| path_code | output | 2 | Path taken by the flit of the previous cycle |

## Verification
Wrong state in this block shows at the ports fast. A head-of-line age that is off by one moves `sa_req` and the crossbar output by a cycle, and the first buffered flit exposes it. A wrong read pointer or stale FIFO entry puts the wrong data or channel on `xbar_data`/`xbar_vc` on the next forwarding. A credit counter that drifts shows only when it reaches zero. Either `sa_req` stays low while credit is still owed, or an extra flit leaves. For this reason the bench drains a channel's credits completely and refills them.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        ROLE_NORMAL = 2'd0,
        ROLE_SOURCE = 2'd1,
        ROLE_BYPASS = 2'd2,
        ROLE_SINK   = 2'd3
    } evc_role_e;

    typedef enum logic [1:0] {
        PATH_NONE     = 2'd0,
        PATH_BUFFERED = 2'd1,
        PATH_BYPASS   = 2'd2
    } evc_path_e;

    // head-of-line cycles spent before a buffered flit may request the switch
    localparam int unsigned ALLOC_STAGES = 3;

endpackage

// File: rtl/evc_credit_bank.sv
module evc_credit_bank #(
    parameter int VC_N    = 4,
    parameter int CREDITS = 3,
    localparam int VC_W   = (VC_N > 1) ? $clog2(VC_N) : 1,
    localparam int CNT_W  = $clog2(CREDITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_valid,
    input  logic [VC_W-1:0] take_vc,
    input  logic            ret_valid,
    input  logic [VC_W-1:0] ret_vc,
    output logic [VC_N-1:0] credit_ok
);

    for (genvar g = 0; g < VC_N; g++) begin : g_lane
        logic [CNT_W-1:0] cnt_d, cnt_q;
        logic             dec, inc;

        always_comb begin
            dec   = take_valid && (take_vc == VC_W'(g));
            inc   = ret_valid && (ret_vc == VC_W'(g));
            cnt_d = cnt_q;
            if (inc && !dec && (cnt_q != CNT_W'(CREDITS))) begin
                cnt_d = cnt_q + 1'b1;
            end else if (dec && !inc && (cnt_q != '0)) begin
                cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= CNT_W'(CREDITS);
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign credit_ok[g] = (cnt_q != '0);
    end

endmodule

// File: rtl/evc_input_buf.sv
module evc_input_buf #(
    parameter int VC_W    = 2,
    parameter int PORT_W  = 3,
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 4,
    parameter int AGE_MAX = 3,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int AGE_W  = $clog2(AGE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [VC_W-1:0]   push_vc,
    input  logic [PORT_W-1:0] push_port,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_gated,
    input  logic              pop,
    output logic              head_ready,
    output logic [VC_W-1:0]   head_vc,
    output logic [PORT_W-1:0] head_port,
    output logic [DATA_W-1:0] head_data,
    output logic              head_gated,
    output logic              full
);

    typedef struct packed {
        logic [VC_W-1:0]   vc;
        logic [PORT_W-1:0] port;
        logic [DATA_W-1:0] data;
        logic              gated;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0]            mem;
        logic   [DEPTH-1:0][AGE_W-1:0] age;
        logic   [PTR_W-1:0]            rd;
        logic   [PTR_W-1:0]            wr;
        logic   [CNT_W-1:0]            cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // every slot ages by one per cycle, saturating at the allocation depth
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.age[i] < AGE_W'(AGE_MAX)) begin
                st_d.age[i] = st_q.age[i] + 1'b1;
            end
        end
        if (pop) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        if (push) begin
            st_d.mem[st_q.wr].vc    = push_vc;
            st_d.mem[st_q.wr].port  = push_port;
            st_d.mem[st_q.wr].data  = push_data;
            st_d.mem[st_q.wr].gated = push_gated;
            st_d.age[st_q.wr]       = AGE_W'(1);
            st_d.wr                 = st_q.wr + 1'b1;
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_ready = (st_q.cnt != '0) && (st_q.age[st_q.rd] >= AGE_W'(AGE_MAX));
    assign head_vc    = st_q.mem[st_q.rd].vc;
    assign head_port  = st_q.mem[st_q.rd].port;
    assign head_data  = st_q.mem[st_q.rd].data;
    assign head_gated = st_q.mem[st_q.rd].gated;
    assign full       = (st_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/evc_path_sel.sv
module evc_path_sel
    import evc_pkg::*;
#(
    parameter int VC_N  = 4,
    localparam int VC_W = (VC_N > 1) ? $clog2(VC_N) : 1
) (
    input  logic            in_valid,
    input  logic            in_express,
    input  logic [1:0]      in_role,
    input  logic            head_ready,
    input  logic            head_gated,
    input  logic [VC_W-1:0] head_vc,
    input  logic [VC_N-1:0] credit_ok,
    input  logic            sa_gnt,
    output logic            take_bypass,
    output logic            take_buffer,
    output logic            sa_req,
    output logic            launch,
    output logic            consume
);

    logic head_has_credit;

    always_comb begin
        head_has_credit = !head_gated || credit_ok[head_vc];
        take_bypass     = in_valid && in_express && (in_role == ROLE_BYPASS);
        take_buffer     = in_valid && !take_bypass;
        // a bypassing flit owns the crossbar slot of this input this cycle
        sa_req          = head_ready && head_has_credit && !take_bypass;
        launch          = sa_req && sa_gnt;
        consume         = launch && head_gated;
    end

endmodule

// File: rtl/evc_bypass_ctrl.sv
module evc_bypass_ctrl
    import evc_pkg::*;
#(
    parameter int NUM_VC    = 4,
    parameter int NUM_PORT  = 5,
    parameter int DATA_W    = 32,
    parameter int BUF_DEPTH = 4,
    parameter int CREDITS   = 3,
    localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int PORT_W   = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flit_valid,
    input  logic                flit_express,
    input  logic [1:0]          flit_role,
    input  logic [VC_W-1:0]     flit_vc,
    input  logic [PORT_W-1:0]   flit_port,
    input  logic [DATA_W-1:0]   flit_data,
    input  logic                sa_gnt,
    output logic                sa_req,
    input  logic                cred_ret_valid,
    input  logic [VC_W-1:0]     cred_ret_vc,
    output logic                xbar_valid,
    output logic [NUM_PORT-1:0] xbar_req,
    output logic                xbar_bypass,
    output logic [VC_W-1:0]     xbar_vc,
    output logic [DATA_W-1:0]   xbar_data,
    output logic [1:0]          path_code
);

    typedef struct packed {
        logic                valid;
        logic                bypass;
        logic [NUM_PORT-1:0] req;
        logic [VC_W-1:0]     vc;
        logic [DATA_W-1:0]   data;
        logic [1:0]          path;
    } out_t;

    out_t out_d, out_q;

    logic              take_bypass, take_buffer, launch, consume;
    logic              head_ready, head_gated, buf_full;
    logic [VC_W-1:0]   head_vc;
    logic [PORT_W-1:0] head_port;
    logic [DATA_W-1:0] head_data;
    logic [NUM_VC-1:0] credit_ok;
    logic              push_gated;

    assign push_gated = flit_express && (flit_role == ROLE_SOURCE);

    evc_path_sel #(.VC_N(NUM_VC)) u_sel (
        .in_valid   (flit_valid),
        .in_express (flit_express),
        .in_role    (flit_role),
        .head_ready (head_ready),
        .head_gated (head_gated),
        .head_vc    (head_vc),
        .credit_ok  (credit_ok),
        .sa_gnt     (sa_gnt),
        .take_bypass(take_bypass),
        .take_buffer(take_buffer),
        .sa_req     (sa_req),
        .launch     (launch),
        .consume    (consume)
    );

    evc_input_buf #(
        .VC_W   (VC_W),
        .PORT_W (PORT_W),
        .DATA_W (DATA_W),
        .DEPTH  (BUF_DEPTH),
        .AGE_MAX(int'(ALLOC_STAGES))
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take_buffer),
        .push_vc   (flit_vc),
        .push_port (flit_port),
        .push_data (flit_data),
        .push_gated(push_gated),
        .pop       (launch),
        .head_ready(head_ready),
        .head_vc   (head_vc),
        .head_port (head_port),
        .head_data (head_data),
        .head_gated(head_gated),
        .full      (buf_full)
    );

    evc_credit_bank #(
        .VC_N   (NUM_VC),
        .CREDITS(CREDITS)
    ) u_cred (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_valid(consume),
        .take_vc   (head_vc),
        .ret_valid (cred_ret_valid),
        .ret_vc    (cred_ret_vc),
        .credit_ok (credit_ok)
    );

    always_comb begin
        out_d = '0;
        if (take_bypass) begin
            out_d.valid  = 1'b1;
            out_d.bypass = 1'b1;
            out_d.req    = NUM_PORT'(1) << flit_port;
            out_d.vc     = flit_vc;
            out_d.data   = flit_data;
        end else if (launch) begin
            out_d.valid  = 1'b1;
            out_d.req    = NUM_PORT'(1) << head_port;
            out_d.vc     = head_vc;
            out_d.data   = head_data;
        end
        if (take_bypass) begin
            out_d.path = PATH_BYPASS;
        end else if (take_buffer) begin
            out_d.path = PATH_BUFFERED;
        end else begin
            out_d.path = PATH_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign xbar_valid  = out_q.valid;
    assign xbar_req    = out_q.req;
    assign xbar_bypass = out_q.bypass;
    assign xbar_vc     = out_q.vc;
    assign xbar_data   = out_q.data;
    assign path_code   = out_q.path;

endmodule

// File: rtl/evc_bypass_chk.sv
module evc_bypass_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flit_valid,
    input logic       flit_express,
    input logic [1:0] flit_role,
    input logic       sa_req,
    input logic       sa_gnt,
    input logic       xbar_valid,
    input logic       xbar_bypass,
    input logic [1:0] path_code,
    input logic       buf_full
);

    logic byp;
    assign byp = flit_valid && flit_express && (flit_role == 2'd2);

    a_r2_bypass_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        byp |=> (xbar_valid && xbar_bypass));

    a_r3_plain_not_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !flit_express) |=> !xbar_bypass);

    a_r5_grant_forwards: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_req && sa_gnt) |=> (xbar_valid && !xbar_bypass));

    a_r5_no_spurious_flit: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && !(sa_req && sa_gnt)) |=> !xbar_valid);

    a_r6_bypass_holds_request: assert property (@(posedge clk) disable iff (!rst_n)
        byp |-> !sa_req);

    a_r7_room_for_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !byp) |-> !buf_full);

    a_r9_path_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        byp |=> (path_code == 2'd2));

    a_r9_path_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !byp) |=> (path_code == 2'd1));

    a_r9_path_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !flit_valid |=> (path_code == 2'd0));

endmodule

bind evc_bypass_ctrl evc_bypass_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flit_valid  (flit_valid),
    .flit_express(flit_express),
    .flit_role   (flit_role),
    .sa_req      (sa_req),
    .sa_gnt      (sa_gnt),
    .xbar_valid  (xbar_valid),
    .xbar_bypass (xbar_bypass),
    .path_code   (path_code),
    .buf_full    (buf_full)
);

// File: tb/sim_evc_bypass_ctrl.sv
module sim_evc_bypass_ctrl;

    localparam int NV  = 4;
    localparam int NP  = 5;
    localparam int DW  = 32;
    localparam int DEP = 4;
    localparam int CR  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flit_valid = 1'b0, flit_express = 1'b0;
    logic [1:0]    flit_role = '0;
    logic [1:0]    flit_vc = '0;
    logic [2:0]    flit_port = '0;
    logic [DW-1:0] flit_data = '0;
    logic          sa_gnt = 1'b0, sa_req;
    logic          cred_ret_valid = 1'b0;
    logic [1:0]    cred_ret_vc = '0;
    logic          xbar_valid, xbar_bypass;
    logic [NP-1:0] xbar_req;
    logic [1:0]    xbar_vc;
    logic [DW-1:0] xbar_data;
    logic [1:0]    path_code;

    always #10 clk = ~clk;

    evc_bypass_ctrl #(
        .NUM_VC(NV), .NUM_PORT(NP), .DATA_W(DW), .BUF_DEPTH(DEP), .CREDITS(CR)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .flit_valid(flit_valid), .flit_express(flit_express), .flit_role(flit_role),
        .flit_vc(flit_vc), .flit_port(flit_port), .flit_data(flit_data),
        .sa_gnt(sa_gnt), .sa_req(sa_req),
        .cred_ret_valid(cred_ret_valid), .cred_ret_vc(cred_ret_vc),
        .xbar_valid(xbar_valid), .xbar_req(xbar_req), .xbar_bypass(xbar_bypass),
        .xbar_vc(xbar_vc), .xbar_data(xbar_data), .path_code(path_code)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // behavioural reference state
    typedef struct { int vc; int port; int data; bit gated; int age; } ent_t;
    ent_t mq[$];
    int   mcred[NV];
    bit   e_valid, e_byp;
    int   e_req, e_vc, e_data, e_path;
    int   seen_norm = 0, seen_byp = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(input bit v, input bit ex, input int role, input int vc,
                        input int port, input int data, input bit gnt,
                        input bit rv, input int rvc);
        bit   byp, elig, req, launch;
        ent_t ne;
        flit_valid = v; flit_express = ex; flit_role = 2'(role);
        flit_vc = 2'(vc); flit_port = 3'(port); flit_data = DW'(data);
        sa_gnt = gnt; cred_ret_valid = rv; cred_ret_vc = 2'(rvc);
        #1;
        byp  = v && ex && (role == 2);
        elig = (mq.size() > 0) && (mq[0].age >= 3) && (!mq[0].gated || mcred[mq[0].vc] > 0);
        req  = elig && !byp;
        launch = req && gnt;
        chk(byp ? "R6" : "R5", "sa_req", int'(sa_req), int'(req));
        @(posedge clk);
        e_path = !v ? 0 : (byp ? 2 : 1);
        if (byp) begin
            e_valid = 1; e_byp = 1; e_req = 1 << port; e_vc = vc; e_data = data;
        end else if (launch) begin
            e_valid = 1; e_byp = 0; e_req = 1 << mq[0].port; e_vc = mq[0].vc; e_data = mq[0].data;
        end else begin
            e_valid = 0; e_byp = 0;
        end
        if (launch && mq[0].gated) mcred[mq[0].vc]--;
        if (rv) mcred[rvc]++;
        if (launch) void'(mq.pop_front());
        foreach (mq[i]) if (mq[i].age < 3) mq[i].age++;
        if (v && !byp) begin
            ne.vc = vc; ne.port = port; ne.data = data;
            ne.gated = ex && (role == 1); ne.age = 1;
            mq.push_back(ne);
        end
        @(negedge clk);
        chk("R9", "path_code", int'(path_code), e_path);
        chk(e_valid ? (e_byp ? "R2" : "R7") : "R3", "xbar_valid", int'(xbar_valid), int'(e_valid));
        if (e_valid) begin
            chk(e_byp ? "R2" : "R7", "xbar_bypass", int'(xbar_bypass), int'(e_byp));
            chk(e_byp ? "R2" : "R7", "xbar_req", int'(xbar_req), e_req);
            chk(e_byp ? "R2" : "R7", "xbar_vc", int'(xbar_vc), e_vc);
            chk(e_byp ? "R2" : "R7", "xbar_data", int'(xbar_data), e_data);
        end
        if (xbar_valid) begin
            if (xbar_bypass) seen_byp++; else seen_norm++;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(0, 0, 0, 0, 0, 0, 1, 0, 0);
    endtask

    task automatic send_measure(input bit ex, input int role, input int vc, input int port,
                                input int data, output int lat, output bit byp_flag);
        tick(1, ex, role, vc, port, data, 1, 0, 0);
        lat = 1;
        while (!xbar_valid && lat < 12) begin
            tick(0, 0, 0, 0, 0, 0, 1, 0, 0);
            lat++;
        end
        byp_flag = xbar_bypass;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lat, base;
        bit bf;
        for (int i = 0; i < NV; i++) mcred[i] = CR;
        e_valid = 0; e_byp = 0; e_req = 0; e_vc = 0; e_data = 0; e_path = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1", "xbar_valid", int'(xbar_valid), 0);
        chk("R1", "xbar_req", int'(xbar_req), 0);
        chk("R1", "path_code", int'(path_code), 0);
        chk("R1", "sa_req", int'(sa_req), 0);
        rst_n = 1'b1;
        idle(2);

        // R2: bypass flit one cycle later
        send_measure(1, 2, 1, 2, 32'h00A5, lat, bf);
        chk("R2", "bypass latency", lat, 1);
        chk("R2", "bypass flag", int'(bf), 1);
        idle(2);

        // R3: plain flit is buffered even if role says bypass
        send_measure(0, 2, 0, 3, 77, lat, bf);
        chk("R3", "plain latency", lat, 4);
        chk("R3", "plain bypass flag", int'(bf), 0);
        idle(2);

        // R4: express flits at source, sink, normal role use the full path
        send_measure(1, 1, 1, 4, 11, lat, bf);
        chk("R4", "source latency", lat, 4);
        send_measure(1, 3, 3, 0, 12, lat, bf);
        chk("R4", "sink latency", lat, 4);
        send_measure(1, 0, 2, 1, 13, lat, bf);
        chk("R4", "normal-role express latency", lat, 4);
        idle(2);

        // R8: exhaust vc2 credits, then return one
        base = seen_norm;
        for (int k = 0; k < 4; k++) tick(1, 1, 1, 2, k, 100 + k, 1, 0, 0);
        idle(10);
        chk("R8", "launches with no return", seen_norm - base, CR);
        chk("R8", "blocked head sa_req", int'(sa_req), 0);
        tick(0, 0, 0, 0, 0, 0, 1, 1, 2);
        idle(8);
        chk("R8", "launches after return", seen_norm - base, CR + 1);
        for (int k = 0; k < CR; k++) tick(0, 0, 0, 0, 0, 0, 1, 1, 2);
        idle(2);

        // R10: sink flits on vc3 ignore credits and leave them intact
        base = seen_norm;
        for (int k = 0; k < 4; k++) tick(1, 1, 3, 3, 1, 200 + k, 1, 0, 0);
        idle(10);
        chk("R10", "sink launches", seen_norm - base, 4);
        base = seen_norm;
        for (int k = 0; k < 4; k++) tick(1, 1, 1, 3, 2, 300 + k, 1, 0, 0);
        idle(10);
        chk("R10", "source launches after sink traffic", seen_norm - base, CR);
        for (int k = 0; k < CR; k++) tick(0, 0, 0, 0, 0, 0, 1, 1, 3);
        idle(8);

        // R6: bypass arrives the cycle the buffered head is eligible
        tick(1, 0, 0, 1, 2, 55, 1, 0, 0);
        idle(2);
        tick(1, 1, 2, 0, 4, 66, 1, 0, 0);
        chk("R6", "bypass wins slot", int'(xbar_valid && xbar_bypass), 1);
        idle(1);
        chk("R6", "head follows next cycle", int'(xbar_valid && !xbar_bypass), 1);
        chk("R6", "head data", int'(xbar_data), 55);
        idle(2);

        // R5: grant withheld keeps head waiting
        tick(1, 0, 0, 2, 1, 88, 0, 0, 0);
        for (int k = 0; k < 6; k++) tick(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R5", "held head requests", int'(sa_req), 1);
        chk("R5", "nothing forwarded without grant", int'(xbar_valid), 0);
        tick(0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk("R5", "forwarded after grant", int'(xbar_valid), 1);
        idle(2);

        // R7: back-to-back buffered flits keep order (checked per cycle)
        for (int k = 0; k < DEP; k++) tick(1, 0, 1, k, k, 400 + k, 1, 0, 0);
        idle(8);

        // mixed traffic against the model
        for (int k = 0; k < 4000; k++) begin
            bit v, ex, g, rv;
            int role, vc, rvc;
            v    = ($urandom % 2) == 0;
            ex   = ($urandom % 2) == 0;
            role = int'($urandom % 4);
            vc   = int'($urandom % NV);
            g    = ($urandom % 10) < 7;
            rvc  = int'($urandom % NV);
            rv   = (($urandom % 3) == 0) && (mcred[rvc] < CR);
            if (v && !(ex && role == 2) && mq.size() >= DEP) v = 0;
            tick(v, ex, role, vc, int'($urandom % NP), int'($urandom), g, rv, rvc);
        end
        idle(12);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule